// File: doc/BRIEF.md
# Slot-Table Frame Source Scheduler

This block decides, one output frame at a time, which of six input channels feeds a downlink multiplexer. Three instruments each own two channels. The schedule is a writable table with one entry per frame slot. It has 1300 entries by default, and a full pass through it covers the whole rate cycle. Each entry holds a 3-bit code. Codes 0 to 5 name an input channel. Codes 6 and 7 order a fill frame. A channel can only send as many frames per pass as the slots that carry its code, so the table sets each instrument's rate limit. At the default depth and frame length, one slot is worth about 0.1 Mbps.

After reset, a sequencer walks a read-only store and copies its defaults into the table, one entry per clock. Until that copy ends, the command port reports not-ready, so a command source holds its write back. Scheduling starts only after the copy. After that, a command can rewrite any single entry while slots keep running. Frame building, encoding and serialization happen downstream. The block only emits a slot strobe with a grant or a fill request.

Top module: `tdm_slot_scheduler`

## Requirements
- R1: Slots are visited in index order 0, 1, …, NUM_SLOTS-1, and after the last slot the next slot is index 0 again.
- R2: When a slot's code is below 6 and that channel's ready flag is high, the slot strobe comes with grantValid=1, fillReq=0 and grantPort equal to the code.
- R3: Codes 6 and 7 (no channel) always give fillReq=1 and grantValid=0.
- R4: When a slot's code names a channel whose ready flag is low at decision time, the slot gives fillReq=1 and grantValid=0.
- R5: After reset, romAddr steps 0, 1, …, NUM_SLOTS-1, one value per clock, and the ROM value present on romData in each cycle is stored at that address. No slot strobe occurs before the copy is done.
- R6: cmdReady stays low for exactly NUM_SLOTS cycles after reset. A write presented while cmdReady is low does not change the table.
- R7: A write (cmdWrite=1 while cmdReady=1) stores cmdData at entry cmdAddr only. All other entries keep their values.
- R8: A write to the slot whose decision has already been made takes effect on the next pass. A write to a slot not yet read in the current pass takes effect in the current pass.
- R9: slotStart is a one-cycle pulse repeating every SLOT_CYCLES clocks. The grant outputs hold their values between pulses.
- R10: During reset, slotStart, grantValid, fillReq and cmdReady are 0, and romAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portReady | input | NUM_PORTS | Per-channel packet-ready flags |
| romAddr | output | IDX_W | Default-store read address during the copy |
| romData | input | CODE_W | Default code at romAddr, valid in the same cycle |
| cmdWrite | input | 1 | Command write request |
| cmdAddr | input | IDX_W | Entry to rewrite |
| cmdData | input | CODE_W | New code for that entry |
| cmdReady | output | 1 | High once the copy has finished; writes are taken only then |
| slotStart | output | 1 | One-cycle pulse marking a new slot decision |
| grantValid | output | 1 | The slot is granted to grantPort |
| grantPort | output | PORT_W | Granted channel index |
| fillReq | output | 1 | The slot must carry a fill frame |

## Verification
A table entry corrupted during the copy or by a misdirected command stays hidden until the scheduler reaches that index. It then shows up as a wrong grant, or as a fill in place of a grant, at that slot's strobe, so a full pass exposes it within NUM_SLOTS × SLOT_CYCLES clocks. A slot index that skips or wraps early shifts every later decision against a model of the table, and this becomes visible on the first slot after the fault. A stuck ready-flag path changes only the grant/fill split, so each channel is driven both ready and not ready over whole passes.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  // Strobes from control to datapath, one per action in a cycle.
  typedef struct packed {
    logic loadWe;   // copy romData into the table at the load address
    logic cmdWe;    // accept a command write
    logic readEn;   // fetch the code of the upcoming slot
    logic decide;   // turn the fetched code into a grant or fill
  } schedStrobe_t;

endpackage

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
#(
  parameter int NUM_SLOTS   = 1300,
  parameter int SLOT_CYCLES = 16,
  localparam int IDX_W      = $clog2(NUM_SLOTS),
  localparam int TIMER_W    = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  output logic [IDX_W-1:0] loadAddr,
  output logic [IDX_W-1:0] readAddr,
  output logic             cmdReady,
  output schedStrobe_t     strobe
);

  localparam logic [IDX_W-1:0]   LAST_SLOT  = IDX_W'(NUM_SLOTS - 1);
  localparam logic [TIMER_W-1:0] LAST_TICK  = TIMER_W'(SLOT_CYCLES - 1);
  localparam logic [TIMER_W-1:0] READ_TICK  = TIMER_W'(0);
  localparam logic [TIMER_W-1:0] DECIDE_TICK = TIMER_W'(1);

  logic               loading;
  logic [IDX_W-1:0]   loadCnt;
  logic [TIMER_W-1:0] slotTimer;
  logic [IDX_W-1:0]   slotIdx;

  // Copy sequencer: one table entry per clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loading <= 1'b1;
      loadCnt <= '0;
    end else if (loading) begin
      if (loadCnt == LAST_SLOT) loading <= 1'b0;
      else                      loadCnt <= loadCnt + 1'b1;
    end
  end

  // Slot timer and slot index, running only once the table is filled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotTimer <= '0;
      slotIdx   <= '0;
    end else if (!loading) begin
      slotTimer <= (slotTimer == LAST_TICK) ? '0 : slotTimer + 1'b1;
      if (slotTimer == DECIDE_TICK)
        slotIdx <= (slotIdx == LAST_SLOT) ? '0 : slotIdx + 1'b1;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.loadWe = loading;
    strobe.cmdWe  = cmdWrite && !loading;
    strobe.readEn = !loading && (slotTimer == READ_TICK);
    strobe.decide = !loading && (slotTimer == DECIDE_TICK);
  end

  assign loadAddr = loadCnt;
  assign readAddr = slotIdx;
  assign cmdReady = !loading;

  AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decide && slotIdx == LAST_SLOT) |=> (slotIdx == '0)); // R1

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decide && slotIdx != LAST_SLOT) |=> (slotIdx == $past(slotIdx) + 1'b1)); // R1

  AST_NO_DECIDE_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !(strobe.decide || strobe.readEn)); // R5

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReady) |-> ($past(loadAddr) == LAST_SLOT)); // R6

  AST_NO_CMD_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWe |-> !strobe.cmdWe); // R6

endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 1300,
  parameter int NUM_PORTS = 6,
  parameter int CODE_W    = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int PORT_W   = $clog2(NUM_PORTS),
  localparam int CODE_NUM = 1 << CODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  schedStrobe_t         strobe,
  input  logic [IDX_W-1:0]     loadAddr,
  input  logic [IDX_W-1:0]     readAddr,
  input  logic [CODE_W-1:0]    romData,
  input  logic [IDX_W-1:0]     cmdAddr,
  input  logic [CODE_W-1:0]    cmdData,
  input  logic [NUM_PORTS-1:0] portReady,
  output logic                 slotStart,
  output logic                 grantValid,
  output logic [PORT_W-1:0]    grantPort,
  output logic                 fillReq
);

  logic [CODE_W-1:0]   table_q [NUM_SLOTS];
  logic [CODE_W-1:0]   rdCode;
  logic [CODE_NUM-1:0] readyByCode;
  logic                takeIt;

  // Codes beyond the channel count never see a ready flag.
  for (genvar c = 0; c < CODE_NUM; c++) begin : g_code_ready
    if (c < NUM_PORTS) begin : g_port
      assign readyByCode[c] = portReady[c];
    end else begin : g_fill
      assign readyByCode[c] = 1'b0;
    end
  end

  // Single write port: the copy owns it while running, commands afterwards.
  always_ff @(posedge clk) begin
    if (strobe.loadWe)     table_q[loadAddr] <= romData;
    else if (strobe.cmdWe) table_q[cmdAddr]  <= cmdData;
  end

  // Registered read: a same-edge write to this entry is seen next pass.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdCode <= '0;
    else if (strobe.readEn) rdCode <= table_q[readAddr];
  end

  assign takeIt = readyByCode[rdCode];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotStart  <= 1'b0;
      grantValid <= 1'b0;
      grantPort  <= '0;
      fillReq    <= 1'b0;
    end else begin
      slotStart <= strobe.decide;
      if (strobe.decide) begin
        grantValid <= takeIt;
        fillReq    <= !takeIt;
        grantPort  <= takeIt ? PORT_W'(rdCode) : '0;
      end
    end
  end

  AST_GRANT_XOR_FILL: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |-> (grantValid != fillReq)); // R2

  AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && grantValid) |-> ((($past(portReady) >> grantPort) & NUM_PORTS'(1)) != '0)); // R4

  AST_BAD_CODE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (slotStart && (32'(rdCode) >= NUM_PORTS)) |-> fillReq); // R3

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> !slotStart); // R9

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !slotStart |-> ($stable(grantValid) && $stable(fillReq) && $stable(grantPort))); // R9

endmodule

// File: rtl/tdm_slot_scheduler.sv
module tdm_slot_scheduler
  import tdm_slot_pkg::*;
#(
  parameter int NUM_SLOTS   = 1300,
  parameter int NUM_PORTS   = 6,
  parameter int CODE_W      = 3,
  parameter int SLOT_CYCLES = 16,
  localparam int IDX_W      = $clog2(NUM_SLOTS),
  localparam int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] portReady,
  output logic [IDX_W-1:0]     romAddr,
  input  logic [CODE_W-1:0]    romData,
  input  logic                 cmdWrite,
  input  logic [IDX_W-1:0]     cmdAddr,
  input  logic [CODE_W-1:0]    cmdData,
  output logic                 cmdReady,
  output logic                 slotStart,
  output logic                 grantValid,
  output logic [PORT_W-1:0]    grantPort,
  output logic                 fillReq
);

  schedStrobe_t     strobe;
  logic [IDX_W-1:0] loadAddr;
  logic [IDX_W-1:0] readAddr;

  tdm_slot_ctrl #(
    .NUM_SLOTS  (NUM_SLOTS),
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWrite(cmdWrite),
    .loadAddr(loadAddr),
    .readAddr(readAddr),
    .cmdReady(cmdReady),
    .strobe  (strobe)
  );

  tdm_slot_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_PORTS(NUM_PORTS),
    .CODE_W   (CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadAddr  (loadAddr),
    .readAddr  (readAddr),
    .romData   (romData),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .portReady (portReady),
    .slotStart (slotStart),
    .grantValid(grantValid),
    .grantPort (grantPort),
    .fillReq   (fillReq)
  );

  assign romAddr = loadAddr;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |-> !slotStart); // R5

endmodule

// File: tb/tdm_slot_scheduler_test.sv
module tdm_slot_scheduler_test;

  localparam int NS = 8;
  localparam int NP = 6;
  localparam int SC = 4;
  localparam int IW = $clog2(NS);

  localparam logic [NP-1:0] READY_VEC [6] = '{6'h3f, 6'h00, 6'h15, 6'h2a, 6'h3c, 6'h03};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] portReady = '0;
  logic [IW-1:0] romAddr;
  logic [2:0]    romData;
  logic          cmdWrite = 1'b0;
  logic [IW-1:0] cmdAddr = '0;
  logic [2:0]    cmdData = '0;
  logic          cmdReady, slotStart, grantValid, fillReq;
  logic [2:0]    grantPort;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int slotCount = 0;
  int lastStart = -1;
  int expTab [NS];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] romCode(int a);
    return 3'((a * 5 + 1) % 8);
  endfunction

  assign romData = romCode(int'(romAddr));

  tdm_slot_scheduler #(.NUM_SLOTS(NS), .NUM_PORTS(NP), .CODE_W(3), .SLOT_CYCLES(SC)) uut (
    .clk(clk), .rstN(rstN), .portReady(portReady), .romAddr(romAddr), .romData(romData),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdReady(cmdReady),
    .slotStart(slotStart), .grantValid(grantValid), .grantPort(grantPort), .fillReq(fillReq)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Wait for the next slot strobe, sampled at a falling edge; also checks spacing (R9).
  task automatic waitSlot();
    do @(negedge clk); while (!slotStart);
    if (lastStart >= 0) check((cyc - lastStart) == SC, "R9 spacing", cyc - lastStart, SC);
    lastStart = cyc;
  endtask

  // Compare one slot decision against the table model (R1..R4).
  task automatic checkSlot();
    int s    = slotCount % NS;
    int code = expTab[s];
    bit want = (code < NP) && portReady[code];
    string tag = (code >= NP) ? "R3 bad code fill" : (want ? "R2 grant" : "R4 not ready fill");
    check(grantValid == want, tag, grantValid, want);
    check(fillReq == !want, tag, fillReq, !want);
    if (want) check(grantPort == 3'(code), "R1 slot order / R2 port", grantPort, code);
    slotCount++;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int idx;
    for (int i = 0; i < NS; i++) expTab[i] = int'(romCode(i));

    // R10: reset state
    repeat (3) @(negedge clk);
    check(slotStart == 0, "R10 slotStart", slotStart, 0);
    check(grantValid == 0, "R10 grantValid", grantValid, 0);
    check(fillReq == 0, "R10 fillReq", fillReq, 0);
    check(cmdReady == 0, "R10 cmdReady", cmdReady, 0);
    check(romAddr == 0, "R10 romAddr", romAddr, 0);

    // Release reset; R6: write during the copy must be ignored
    rstN = 1'b1;
    cmdWrite = 1'b1; cmdAddr = '0; cmdData = 3'd7;
    idx = 0;
    #1;
    while (!cmdReady && idx < 4 * NS) begin
      check(romAddr == IW'(idx), "R5 rom address order", romAddr, idx);
      check(slotStart == 0, "R5 no slot during copy", slotStart, 0);
      @(negedge clk);
      cmdWrite = 1'b0;
      idx++;
    end
    check(idx == NS, "R6 copy length", idx, NS);

    // Vector table: one full pass per ready pattern
    for (int v = 0; v < 6; v++) begin
      portReady = READY_VEC[v];
      for (int k = 0; k < NS; k++) begin
        waitSlot();
        if (v == 0 && k == 0) check(grantValid && grantPort == 3'(romCode(0)), "R6 early write ignored", grantPort, romCode(0));
        checkSlot();
        @(negedge clk);
        check(slotStart == 0, "R9 pulse width", slotStart, 0);
      end
    end

    // R7/R8: rewrite the slot just decided and the one after it
    portReady = 6'h3f;
    waitSlot();
    checkSlot();
    idx = (slotCount - 1) % NS;
    cmdWrite = 1'b1; cmdAddr = IW'(idx); cmdData = 3'd7;
    @(negedge clk);
    cmdAddr = IW'((idx + 1) % NS); cmdData = 3'd2;
    @(negedge clk);
    cmdWrite = 1'b0;
    // Slot idx was already granted with its old code; next slot uses new code now.
    expTab[(idx + 1) % NS] = 2;
    waitSlot();
    check(grantValid && grantPort == 3'd2, "R8 unread slot updated this pass", grantPort, 2);
    checkSlot();
    expTab[idx] = 7;
    for (int k = 0; k < 2 * NS - 2; k++) begin
      waitSlot();
      if (slotCount % NS == idx) check(fillReq == 1, "R8 decided slot updated next pass", fillReq, 1);
      checkSlot();   // R7: untouched entries still follow the model
    end

    finishRun();
  end

endmodule